// File: doc/BRIEF.md
# Forward-Channel Run-Length Expander

This block sits on the receiving side of a forward byte channel. Each incoming byte has a sideband flag that marks it as a command or as data. A command byte does one of two things. It can set a 7-bit channel address, which the block holds on a registered output. It can load a run-length count, which applies to the next data byte only. That data byte is then sent on the output stream count+1 times. A data byte with no count in front of it goes through once.

Both streams use valid/ready handshakes. A byte moves across an interface only on a clock edge where valid and ready are both high. `in_ready` is high when the output register is empty, or when its last copy leaves in this cycle. `in_ready` covers command bytes as well as data bytes. While copies of a run are still waiting, the input stalls. The output holds its byte and valid until the consumer takes it, so back-pressure never drops or changes a byte. The channel address changes only when an address command is accepted.

Top module: `ecp_rle_expander`

## Requirements
- R1: A synchronous reset sets `out_valid` to 0, `chan_addr` to 0 and `in_ready` to 1, and clears any pending count, so a data byte after reset is emitted once.
- R2: An accepted command byte with bit 7 = 1 loads bits 6..0 into `chan_addr` on the same clock edge. It emits no output byte. `chan_addr` changes at no other time except reset.
- R3: An accepted command byte with bit 7 = 0 loads bits 6..0 as a count N and emits nothing. The next accepted data byte is then emitted exactly N+1 times, and the count is used up.
- R4: A count of 0 emits the following data byte once. A count of 127 emits it 128 times.
- R5: A count of 1 emits the following data byte exactly twice.
- R6: A data byte accepted with no pending count is emitted exactly once. The output emits no byte that the rules above do not call for.
- R7: While more than one copy of the current byte is still owed, `in_ready` is 0. When nothing is owed, `in_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_byte` hold steady on the next cycle, and `in_ready` is 0.
- R9: An address command accepted between a count command and its data byte cancels the count, so that data byte is emitted once.
- R10: Command and data are told apart only by `in_cmd`. A byte with `in_cmd` = 0 is data whatever its value, for example 8'h85, and it leaves `chan_addr` unchanged.
- R11: A data byte accepted on one edge is presented on `out_valid`/`out_byte` right after that edge. With `out_ready` held high, the copies of a run leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_byte | input | 8 | Input byte |
| in_cmd | input | 1 | 1: byte is a command, 0: byte is data |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte this cycle |
| out_byte | output | 8 | Output data byte |
| chan_addr | output | 7 | Most recently set channel address |

## Verification
Every result is due one clock edge after the handshake that causes it. An address command shows on `chan_addr` just after its accepting edge. An accepted data byte shows on `out_valid` just after its accepting edge. Each further copy follows one edge after an output handshake. The bench samples all ports one nanosecond before each rising edge. It keeps a queue of owed output bytes and an expected address, and it updates them only from the handshakes seen at that sample. So on every cycle it can demand three things: `out_valid` is high exactly when the queue is not empty, the front of the queue matches `out_byte` at each output handshake, and `in_ready` is low while more than one copy is owed.

// File: rtl/ecp_rle_pkg.sv
package ecp_rle_pkg;

  // Meaning of one input byte after decoding
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_COUNT = 2'd2
  } byte_kind_e;

  // Width of the payload field carried by a command byte
  function automatic int field_width(input int data_w);
    return data_w - 1;
  endfunction

endpackage

// File: rtl/ecp_cmd_decode.sv
module ecp_cmd_decode
  import ecp_rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W - 1
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cmd_i,
  output byte_kind_e        kind_o,
  output logic [FW-1:0]     field_o
);

  // The top bit of a command byte selects between address and count;
  // the sideband flag alone separates commands from data.
  always_comb begin
    field_o = byte_i[FW-1:0];
    if (!cmd_i) begin
      kind_o = KIND_DATA;
    end else if (byte_i[DATA_W-1]) begin
      kind_o = KIND_ADDR;
    end else begin
      kind_o = KIND_COUNT;
    end
  end

endmodule

// File: rtl/ecp_cmd_state.sv
module ecp_cmd_state
  import ecp_rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  byte_kind_e    kind_i,
  input  logic [FW-1:0] field_i,
  output logic [FW-1:0] addr_o,
  output logic          pend_o,
  output logic [FW-1:0] pend_cnt_o
);

  logic [FW-1:0] addr_q;
  logic          pend_q;
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_i) begin
      unique case (kind_i)
        KIND_ADDR: begin
          addr_q <= field_i;
          pend_q <= 1'b0;   // address command drops a waiting count
        end
        KIND_COUNT: begin
          pend_q <= 1'b1;
          cnt_q  <= field_i;
        end
        default: begin
          pend_q <= 1'b0;   // data byte consumes the count
        end
      endcase
    end
  end

  assign addr_o     = addr_q;
  assign pend_o     = pend_q;
  assign pend_cnt_o = cnt_q;

endmodule

// File: rtl/ecp_repeat_stage.sv
module ecp_repeat_stage #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_byte_i,
  input  logic [CNT_W-1:0]  load_extra_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_byte_o,
  output logic              free_o
);

  logic              vld_q;
  logic [DATA_W-1:0] byte_q;
  logic [CNT_W-1:0]  extra_q;   // copies still owed after the one shown
  logic              last_copy;

  assign last_copy = (extra_q == '0);
  assign free_o    = !vld_q || (out_ready_i && last_copy);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      byte_q  <= '0;
      extra_q <= '0;
    end else if (load_i) begin
      vld_q   <= 1'b1;
      byte_q  <= load_byte_i;
      extra_q <= load_extra_i;
    end else if (vld_q && out_ready_i) begin
      if (last_copy) begin
        vld_q <= 1'b0;
      end else begin
        extra_q <= extra_q - 1'b1;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_byte_o  = byte_q;

endmodule

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander
  import ecp_rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_cmd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic [FW-1:0]     chan_addr
);

  byte_kind_e    kind;
  logic [FW-1:0] field;
  logic          accept;
  logic          pend;
  logic [FW-1:0] pend_cnt;
  logic          stage_free;
  logic          load;
  logic [FW-1:0] extra;

  ecp_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .byte_i (in_byte),
    .cmd_i  (in_cmd),
    .kind_o (kind),
    .field_o(field)
  );

  assign in_ready = stage_free;
  assign accept   = in_valid && in_ready;
  assign load     = accept && (kind == KIND_DATA);
  assign extra    = pend ? pend_cnt : '0;

  ecp_cmd_state #(.DATA_W(DATA_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .kind_i    (kind),
    .field_i   (field),
    .addr_o    (chan_addr),
    .pend_o    (pend),
    .pend_cnt_o(pend_cnt)
  );

  ecp_repeat_stage #(.DATA_W(DATA_W), .CNT_W(FW)) u_rep (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .load_byte_i (in_byte),
    .load_extra_i(extra),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_byte_o  (out_byte),
    .free_o      (stage_free)
  );

endmodule

// File: rtl/ecp_rle_expander_chk.sv
module ecp_rle_expander_chk #(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_byte,
  input logic              in_cmd,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_byte,
  input logic [FW-1:0]     chan_addr
);

  logic addr_fire;
  logic data_fire;
  assign addr_fire = in_valid && in_ready && in_cmd && in_byte[DATA_W-1];
  assign data_fire = in_valid && in_ready && !in_cmd;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && chan_addr == '0));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_fire |=> chan_addr == $past(in_byte[FW-1:0]));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_fire |=> $stable(chan_addr));

  // R11
  data_latency_chk: assert property (@(posedge clk) disable iff (rst)
    data_fire |=> (out_valid && out_byte == $past(in_byte)));

  // R8
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R8
  stall_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind ecp_rle_expander ecp_rle_expander_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_byte  (in_byte),
  .in_cmd   (in_cmd),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_byte (out_byte),
  .chan_addr(chan_addr)
);

// File: tb/ecp_rle_expander_tb.sv
module ecp_rle_expander_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       in_cmd = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic [6:0] chan_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int rdy_mode = 0;   // 0: always ready, 1: pseudo-random, 2: held low
  logic last_in_fire = 1'b0;

  // reference model state
  logic [7:0] exp_q[$];
  logic [6:0] exp_addr = 7'd0;
  bit         m_pend = 0;
  int         m_cnt = 0;

  always #5 clk = ~clk;

  ecp_rle_expander u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_cmd(in_cmd), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .chan_addr(chan_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one sample per cycle, 1 ns before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (rst) begin
      exp_q.delete();
      exp_addr = 7'd0;
      m_pend = 0;
      last_in_fire = 1'b0;
    end else begin
      // R2 R10: address equals last accepted address command
      check(chan_addr == exp_addr, "R2/R10 chan_addr", chan_addr, exp_addr);
      // R6 R11: output valid exactly when a byte is owed
      check(out_valid == (exp_q.size() > 0), "R6/R11 out_valid", out_valid, exp_q.size() > 0);
      // R7: input stalls while more than one copy is owed, open when nothing owed
      if (exp_q.size() > 1) check(!in_ready, "R7 in_ready busy", in_ready, 0);
      if (exp_q.size() == 0) check(in_ready, "R7 in_ready idle", in_ready, 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() > 0) begin
          check(out_byte == exp_q[0], "R3/R4/R5/R8 out_byte", out_byte, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      last_in_fire = in_valid && in_ready;
      if (last_in_fire) begin
        if (in_cmd) begin
          if (in_byte[7]) begin
            exp_addr = in_byte[6:0];
            m_pend = 0;
          end else begin
            m_pend = 1;
            m_cnt = in_byte[6:0];
          end
        end else begin
          for (int k = 0; k < (m_pend ? m_cnt + 1 : 1); k++) exp_q.push_back(in_byte);
          m_pend = 0;
        end
      end
    end
  end

  // output ready pattern
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= ($urandom % 3) != 0;
      default: out_ready <= 1'b0;
    endcase
  end

  task automatic send(input bit cmd, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_cmd   = cmd;
    in_byte  = b;
    do @(negedge clk); while (!last_in_fire);
    in_valid = 1'b0;
    in_cmd   = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() > 0 || out_valid) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // count cycles with out_valid while draining a run (R11 back-to-back)
  task automatic timed_run(input int n, input logic [7:0] b);
    int cyc = 0;
    rdy_mode = 0;
    send(1'b1, 8'(n - 1));
    send(1'b0, b);
    while (out_valid && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    // first copy shown at this negedge's previous edge; n copies take n cycles
    check(cyc == n, "R11 run duration", cyc, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(chan_addr == 7'd0, "R1 chan_addr", chan_addr, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);

    // R6 plain data
    send(1'b0, 8'h3C);
    send(1'b0, 8'hC3);
    drain();
    // R10 data with top bit set stays data
    send(1'b0, 8'h85);
    drain();
    check(chan_addr == 7'd0, "R10 addr untouched", chan_addr, 0);
    // R2 address command
    send(1'b1, 8'h85);
    drain();
    check(chan_addr == 7'h05, "R2 addr loaded", chan_addr, 5);
    // R4 count 0, R5 count 1, R3 count 4
    send(1'b1, 8'h00); send(1'b0, 8'hA1);
    send(1'b1, 8'h01); send(1'b0, 8'hB2);
    send(1'b1, 8'h04); send(1'b0, 8'hC4);
    drain();
    // R9 address between count and data cancels count
    send(1'b1, 8'h06); send(1'b1, 8'hFF); send(1'b0, 8'h77);
    drain();
    check(chan_addr == 7'h7F, "R9 addr", chan_addr, 127);
    // R4 maximum run under back-pressure, R8
    rdy_mode = 1;
    send(1'b1, 8'h7F); send(1'b0, 8'h5A);
    send(1'b0, 8'h11);
    drain();
    // R8 held stall then release
    rdy_mode = 2;
    send(1'b1, 8'h02); send(1'b0, 8'h99);
    repeat (10) @(negedge clk);
    check(out_valid && out_byte == 8'h99, "R8 held byte", out_byte, 8'h99);
    rdy_mode = 0;
    drain();
    // R11 back-to-back copies
    timed_run(5, 8'hE7);
    timed_run(1, 8'h42);
    drain();
    // R1 reset clears a pending count
    send(1'b1, 8'h09);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check(chan_addr == 7'd0, "R1 addr after reset", chan_addr, 0);
    send(1'b0, 8'h6D);
    drain();
    // mixed random traffic
    rdy_mode = 1;
    for (int i = 0; i < 200; i++) begin
      int r = $urandom % 6;
      if (r == 0) send(1'b1, {1'b0, 7'($urandom % 6)});
      else if (r == 1) send(1'b1, {1'b1, 7'($urandom)});
      else send(1'b0, 8'($urandom));
    end
    drain();
    check(exp_q.size() == 0, "R6 nothing owed at end", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule